// File: doc/BRIEF.md
# Byte-Coded Low-Power Sequencer

This block is a per-core power controller. Software loads a 32-byte command store and a small set of registers over a simple 32-bit register bus. It then arms the block and picks the command index at which the next low-power program begins. Several programs live side by side in the store, packed back-to-back with no padding, so a program can begin in the middle of a word.

A wait-for-interrupt pulse from the core launches the armed program. Each command byte either drives the three power-control outputs (clock gate, retention, collapse), inserts a programmable delay, parks the engine until a wake interrupt arrives, or ends the program. The end command clears every power output and pulses a release strobe back to the core. If a program runs off the end of the store without an end command, the engine aborts it and flags an error.

The controller is built around four named states. IDLE waits for an armed launch (transition LAUNCH). RUN executes one command per cycle, via the transitions STEP, PARK, STALL, FINISH and ABORT. WAIT holds until a wake is pending (transition RESUME). DELAY counts down the step delay (transition EXPIRE).

Top module: `lps_sequencer`

## Requirements
- R1: After reset, all power outputs and the release strobe are 0, and the status (offset 0x0C), control (0x30), configuration (0x08) and step-delay (0x34) registers all read 0.
- R2: While the control enable bit (bit 0 of offset 0x30) is 0, a wait-for-interrupt pulse is ignored: the status busy bit stays 0 and the power outputs stay 0.
- R3: The control register keeps only bit 0 (enable) and bits 10:4 (7-bit start index), and other bits read 0. The configuration register at 0x08 keeps all 32 bits.
- R4: The command store is written and read as 8 words at 0x80 + 4*w. Byte i of word w (bits 8i+7:8i) is the command at index 4w+i.
- R5: An enabled wait-for-interrupt launches the program at the start index. LAUNCH takes one cycle, then each drive command (low nibble 0x0 to 0x7) takes one cycle. A drive command puts its bits 0, 1 and 2 onto clock_gate, retention and collapse.
- R6: A command whose low nibble is 0xE parks the engine in WAIT, with the power outputs held and status bit 1 set, until a wake interrupt is seen. Execution then resumes with the next command.
- R7: A wake interrupt that arrives while a program is running but before its wait command is remembered, so the wait command does not stall.
- R8: A command whose low nibble is 0xD holds the outputs for max(N,1) cycles, where N is the step-delay register. The next drive therefore shows N+2 cycles after the drive before the delay (3 cycles when N is 0).
- R9: A command whose low nibble is 0xF clears all power outputs, returns to IDLE and raises core_release for exactly one cycle.
- R10: If the engine is about to execute at index 32 or above, it returns to IDLE, clears the power outputs and sets status bit 2. This happens when a program runs past index 31 or when the start index is 32 or more. A later launch clears bit 2.
- R11: While busy, writes to the control register and to the command store are ignored. Writes to the status register are ignored at all times.
- R12: Status bit 0 is busy and bit 1 is waiting. Bits 8:4 hold the low five bits of the index of the next command, and this value is kept after returning to IDLE. A program that starts right after another program's end byte in the same word runs correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Word-aligned register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wfi_pulse | input | 1 | Core executed wait-for-interrupt |
| wake_irq | input | 1 | Wake interrupt |
| clock_gate | output | 1 | Clock-gate power control |
| retention | output | 1 | Retention power control |
| collapse | output | 1 | Power-collapse control |
| core_release | output | 1 | One-cycle release strobe at program end |

## Verification
The checker assumes that inputs change only between clock edges, and that bus addresses are word aligned. It also assumes that wake_irq is a level the engine may see at any time, with no handshake expected back. The bench drives every input at the falling edge. It uses only the defined register offsets. It builds drive bytes with bit 3 clear, so random programs never contain an unintended control opcode. The control opcodes are placed by hand in the directed cases.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT,
        ST_DELAY
    } lps_state_e;

    typedef enum logic [1:0] {
        CMD_DRIVE,
        CMD_DELAY,
        CMD_WAIT,
        CMD_END
    } lps_cmd_e;

    localparam logic [3:0] OP_END   = 4'hF;
    localparam logic [3:0] OP_WAIT  = 4'hE;
    localparam logic [3:0] OP_DELAY = 4'hD;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_IDX_LSB = 4;
    localparam int CTRL_IDX_W   = 7;
    localparam int STAT_IDX_LSB = 4;

    localparam logic [11:0] ADDR_CFG  = 12'h008;
    localparam logic [11:0] ADDR_STAT = 12'h00C;
    localparam logic [11:0] ADDR_CTRL = 12'h030;
    localparam logic [11:0] ADDR_DLY  = 12'h034;
    localparam logic [11:0] ADDR_SEQ  = 12'h080;

endpackage

// File: rtl/lps_decode.sv
module lps_decode
    import lps_pkg::*;
(
    input  logic [3:0] nib,
    output lps_cmd_e   kind
);

    always_comb begin
        unique case (nib)
            OP_END:   kind = CMD_END;
            OP_WAIT:  kind = CMD_WAIT;
            OP_DELAY: kind = CMD_DELAY;
            default:  kind = CMD_DRIVE;
        endcase
    end

endmodule

// File: rtl/lps_regs.sv
module lps_regs
    import lps_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DLY_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int WORDS = DEPTH / 4,
    localparam int WIW   = $clog2(WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [11:0]           bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  busy,
    input  logic                  waiting,
    input  logic                  err,
    input  logic [IDX_W-1:0]      cur_idx,
    output logic                  ctl_en,
    output logic [CTRL_IDX_W-1:0] ctl_start,
    output logic [DLY_W-1:0]      dly_val,
    output logic [3:0]            cmd_nib
);

    logic [31:0] seq_word [WORDS];
    logic [31:0] cfg_q;
    logic [31:0] cur_word;

    genvar w;
    generate
        for (w = 0; w < WORDS; w++) begin : g_word
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    seq_word[w] <= '0;
                else if (bus_wr && !busy && bus_addr == ADDR_SEQ + 12'(4 * w))
                    seq_word[w] <= bus_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            ctl_start <= '0;
            cfg_q     <= '0;
            dly_val   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_CTRL && !busy) begin
                ctl_en    <= bus_wdata[CTRL_EN_BIT];
                ctl_start <= bus_wdata[CTRL_IDX_LSB +: CTRL_IDX_W];
            end
            if (bus_addr == ADDR_CFG)
                cfg_q <= bus_wdata;
            if (bus_addr == ADDR_DLY)
                dly_val <= bus_wdata[DLY_W-1:0];
        end
    end

    // command fetch: little-endian byte select inside the word
    assign cur_word = seq_word[cur_idx[IDX_W-1:2]];
    assign cmd_nib  = cur_word[{cur_idx[1:0], 3'b000} +: 4];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CFG)
            bus_rdata = cfg_q;
        else if (bus_addr == ADDR_STAT) begin
            bus_rdata[0] = busy;
            bus_rdata[1] = waiting;
            bus_rdata[2] = err;
            bus_rdata[STAT_IDX_LSB +: IDX_W] = cur_idx;
        end else if (bus_addr == ADDR_CTRL) begin
            bus_rdata[CTRL_EN_BIT] = ctl_en;
            bus_rdata[CTRL_IDX_LSB +: CTRL_IDX_W] = ctl_start;
        end else if (bus_addr == ADDR_DLY)
            bus_rdata[DLY_W-1:0] = dly_val;
        else begin
            for (int i = 0; i < WORDS; i++)
                if (bus_addr == ADDR_SEQ + 12'(4 * i))
                    bus_rdata = seq_word[i];
        end
    end

    logic unused_wiw;
    assign unused_wiw = ^WIW;

endmodule

// File: rtl/lps_engine.sv
module lps_engine
    import lps_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DLY_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int IDXP  = IDX_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wfi,
    input  logic                  wake,
    input  logic                  enable,
    input  logic [CTRL_IDX_W-1:0] start_idx,
    input  logic [DLY_W-1:0]      dly_val,
    input  lps_cmd_e              kind,
    input  logic [2:0]            drive_bits,
    output lps_state_e            state,
    output logic [IDX_W:0]        idx,
    output logic [2:0]            pwr,
    output logic                  release_o,
    output logic                  err,
    output logic                  wake_pend
);

    lps_state_e     nxt;
    logic [DLY_W-1:0] dly_cnt;
    logic           overrun;
    logic           launch;

    assign overrun = (idx >= IDXP'(DEPTH));
    assign launch  = wfi && enable;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // next-state: LAUNCH, STEP, PARK, STALL, FINISH, ABORT, RESUME, EXPIRE
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (launch) nxt = ST_RUN;
            ST_RUN: begin
                if (overrun)
                    nxt = ST_IDLE;
                else begin
                    unique case (kind)
                        CMD_END:   nxt = ST_IDLE;
                        CMD_WAIT:  nxt = ST_WAIT;
                        CMD_DELAY: nxt = ST_DELAY;
                        CMD_DRIVE: nxt = ST_RUN;
                    endcase
                end
            end
            ST_WAIT:  if (wake_pend || wake) nxt = ST_RUN;
            ST_DELAY: if (dly_cnt <= DLY_W'(1)) nxt = ST_RUN;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx       <= '0;
            pwr       <= '0;
            release_o <= 1'b0;
            err       <= 1'b0;
            wake_pend <= 1'b0;
            dly_cnt   <= '0;
        end else begin
            release_o <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (launch) begin
                        if (int'(start_idx) >= DEPTH)
                            idx <= IDXP'(DEPTH);
                        else
                            idx <= IDXP'(start_idx);
                        err       <= 1'b0;
                        wake_pend <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (wake) wake_pend <= 1'b1;
                    if (overrun) begin
                        pwr       <= '0;
                        err       <= 1'b1;
                        wake_pend <= 1'b0;
                    end else begin
                        unique case (kind)
                            CMD_END: begin
                                pwr       <= '0;
                                release_o <= 1'b1;
                                wake_pend <= 1'b0;
                            end
                            CMD_WAIT: idx <= idx + 1'b1;
                            CMD_DELAY: begin
                                idx     <= idx + 1'b1;
                                dly_cnt <= dly_val;
                            end
                            CMD_DRIVE: begin
                                pwr <= drive_bits;
                                idx <= idx + 1'b1;
                            end
                        endcase
                    end
                end
                ST_WAIT: begin
                    if (wake_pend || wake) wake_pend <= 1'b0;
                end
                ST_DELAY: begin
                    if (wake) wake_pend <= 1'b1;
                    if (dly_cnt != '0) dly_cnt <= dly_cnt - 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/lps_sequencer.sv
module lps_sequencer
    import lps_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DLY_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        wfi_pulse,
    input  logic        wake_irq,
    output logic        clock_gate,
    output logic        retention,
    output logic        collapse,
    output logic        core_release
);

    localparam int IDX_W = $clog2(DEPTH);

    lps_state_e            st;
    logic [IDX_W:0]        run_idx;
    logic [2:0]            pwr;
    logic                  err_flag;
    logic                  wake_pend;
    logic                  ctl_en;
    logic [CTRL_IDX_W-1:0] ctl_start;
    logic [DLY_W-1:0]      dly_val;
    logic [3:0]            cmd_nib;
    lps_cmd_e              kind;
    logic                  busy;

    assign busy = (st != ST_IDLE);

    lps_regs #(.DEPTH(DEPTH), .DLY_W(DLY_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .waiting   (st == ST_WAIT),
        .err       (err_flag),
        .cur_idx   (run_idx[IDX_W-1:0]),
        .ctl_en    (ctl_en),
        .ctl_start (ctl_start),
        .dly_val   (dly_val),
        .cmd_nib   (cmd_nib)
    );

    lps_decode u_dec (
        .nib  (cmd_nib),
        .kind (kind)
    );

    lps_engine #(.DEPTH(DEPTH), .DLY_W(DLY_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfi        (wfi_pulse),
        .wake       (wake_irq),
        .enable     (ctl_en),
        .start_idx  (ctl_start),
        .dly_val    (dly_val),
        .kind       (kind),
        .drive_bits (cmd_nib[2:0]),
        .state      (st),
        .idx        (run_idx),
        .pwr        (pwr),
        .release_o  (core_release),
        .err        (err_flag),
        .wake_pend  (wake_pend)
    );

    assign clock_gate = pwr[0];
    assign retention  = pwr[1];
    assign collapse   = pwr[2];

endmodule

// File: rtl/lps_checker.sv
module lps_checker
    import lps_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic                  clk,
    input logic                  rst_n,
    input lps_state_e            state,
    input logic [IDX_W:0]        idx,
    input logic [2:0]            pwr,
    input logic                  rel,
    input logic                  err,
    input logic                  enable,
    input logic                  wfi,
    input logic                  wake,
    input logic                  wake_pend,
    input logic                  bus_wr,
    input logic [11:0]           bus_addr,
    input logic [CTRL_IDX_W-1:0] start_idx
);

    assert_disabled_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !enable) |=> (state == ST_IDLE));

    assert_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && enable && wfi) |=> (state == ST_RUN));

    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !wake && !wake_pend) |=> (state == ST_WAIT && $stable(pwr)));

    assert_wake_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN || state == ST_DELAY) && wake) |=> (wake_pend || state == ST_IDLE));

    assert_end_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> (pwr == 3'b000 && state == ST_IDLE));

    assert_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && idx >= (IDX_W+1)'(DEPTH)) |=> (state == ST_IDLE && err && pwr == 3'b000));

    assert_ctrl_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && bus_wr && bus_addr == ADDR_CTRL) |=> ($stable(start_idx) && $stable(enable)));

endmodule

bind lps_sequencer lps_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (st),
    .idx       (run_idx),
    .pwr       (pwr),
    .rel       (core_release),
    .err       (err_flag),
    .enable    (ctl_en),
    .wfi       (wfi_pulse),
    .wake      (wake_irq),
    .wake_pend (wake_pend),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .start_idx (ctl_start)
);

// File: tb/sim_lps_sequencer.sv
module sim_lps_sequencer;

    localparam logic [11:0] A_CFG  = 12'h008;
    localparam logic [11:0] A_STAT = 12'h00C;
    localparam logic [11:0] A_CTRL = 12'h030;
    localparam logic [11:0] A_DLY  = 12'h034;
    localparam logic [11:0] A_SEQ  = 12'h080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wfi_pulse = 1'b0;
    logic        wake_irq = 1'b0;
    logic        clock_gate, retention, collapse, core_release;
    logic [2:0]  pwr_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mem_m [32];

    assign pwr_o = {collapse, retention, clock_gate};

    always #5 clk = ~clk;

    lps_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wfi_pulse(wfi_pulse),
        .wake_irq(wake_irq), .clock_gate(clock_gate), .retention(retention),
        .collapse(collapse), .core_release(core_release)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic load_mem();
        for (int w = 0; w < 8; w++)
            wr(A_SEQ + 12'(4 * w), {mem_m[4*w+3], mem_m[4*w+2], mem_m[4*w+1], mem_m[4*w]});
    endtask

    task automatic fire_wfi();
        @(negedge clk);
        wfi_pulse = 1'b1;
        @(negedge clk);
        wfi_pulse = 1'b0;
    endtask

    function automatic int dly_expect(input int n);
        return ((n < 1) ? 1 : n) + 2;
    endfunction

    function automatic logic [7:0] rand_drive();
        logic [7:0] r;
        r = 8'($urandom);
        return {r[7:4], 1'b0, r[2:0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cnt;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT, d); chk(d == 0, "R1 status", d, 0);
        rd(A_CTRL, d); chk(d == 0, "R1 control", d, 0);
        rd(A_CFG, d);  chk(d == 0, "R1 config", d, 0);
        rd(A_DLY, d);  chk(d == 0, "R1 delay", d, 0);
        chk(pwr_o == 0 && !core_release, "R1 outputs", {28'd0, core_release, pwr_o}, 0);

        // R3 control field masking, config full width
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d); chk(d == 32'h0000_07F1, "R3 control mask", d, 32'h7F1);
        wr(A_CFG, 32'hA5C3_1E77);
        rd(A_CFG, d); chk(d == 32'hA5C3_1E77, "R3 config", d, 32'hA5C3_1E77);
        wr(A_CTRL, 32'h0);

        // R4 / R12 packed programs in one word
        for (int i = 0; i < 32; i++) mem_m[i] = 8'h00;
        mem_m[0] = 8'h01; mem_m[1] = 8'h0F; mem_m[2] = 8'h04; mem_m[3] = 8'h0F;
        load_mem();
        rd(A_SEQ, d); chk(d == 32'h0F04_0F01, "R4 little-endian word", d, 32'h0F040F01);
        wr(A_CTRL, (32'd2 << 4) | 32'd1);
        fire_wfi();
        @(negedge clk); chk(pwr_o == 3'b100, "R12 mid-word program", {29'd0, pwr_o}, 3'b100);
        @(negedge clk); chk(core_release && pwr_o == 0, "R9 release", {28'd0, core_release, pwr_o}, 32'h8);
        @(negedge clk); chk(!core_release, "R9 one-cycle release", {31'd0, core_release}, 0);

        // R2 disabled launch ignored
        wr(A_CTRL, 32'h0);
        fire_wfi();
        for (int k = 0; k < 5; k++) begin
            rd(A_STAT, d);
            chk(d[0] == 1'b0 && pwr_o == 0, "R2 disabled ignore", {d[0], pwr_o}, 0);
        end

        // R5 / R9 random drive programs
        for (int it = 0; it < 20; it++) begin
            int len, st;
            logic [7:0] prog [8];
            len = 1 + int'($urandom % 8);
            st  = int'($urandom % (32 - len));
            for (int i = 0; i < 32; i++) mem_m[i] = 8'($urandom);
            for (int k = 0; k < len; k++) begin
                prog[k] = rand_drive();
                mem_m[st + k] = prog[k];
            end
            mem_m[st + len] = {4'($urandom), 4'hF};
            load_mem();
            wr(A_CTRL, (32'(st) << 4) | 32'd1);
            fire_wfi();
            for (int k = 0; k < len; k++) begin
                @(negedge clk);
                chk(pwr_o == prog[k][2:0], "R5 drive step", {29'd0, pwr_o}, {29'd0, prog[k][2:0]});
            end
            @(negedge clk);
            chk(core_release && pwr_o == 0, "R9 end clears", {28'd0, core_release, pwr_o}, 32'h8);
        end

        // R8 delay command
        for (int t = 0; t < 4; t++) begin
            int n;
            n = (t == 0) ? 0 : 1 + int'($urandom % 20);
            for (int i = 0; i < 32; i++) mem_m[i] = 8'h00;
            mem_m[0] = 8'h01; mem_m[1] = 8'h0D; mem_m[2] = 8'h03; mem_m[3] = 8'h0F;
            load_mem();
            wr(A_DLY, 32'(n));
            wr(A_CTRL, 32'h1);
            fire_wfi();
            @(negedge clk);
            cnt = 0;
            while (!retention && cnt < 40) begin
                @(negedge clk);
                cnt++;
            end
            chk(cnt == dly_expect(n), "R8 delay length", 32'(cnt), 32'(dly_expect(n)));
            repeat (3) @(negedge clk);
        end

        // R6 / R11 wait with writes while busy
        mem_m[0] = 8'h02; mem_m[1] = 8'h0E; mem_m[2] = 8'h05; mem_m[3] = 8'h0F;
        load_mem();
        wr(A_CTRL, 32'h1);
        fire_wfi();
        repeat (3) @(negedge clk);
        rd(A_STAT, d); chk(d == 32'h23, "R6 waiting status", d, 32'h23);
        chk(pwr_o == 3'b010, "R6 outputs held", {29'd0, pwr_o}, 3'b010);
        wr(A_CTRL, 32'h0);
        wr(A_SEQ, 32'hFFFF_FFFF);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_CTRL, d); chk(d == 32'h1, "R11 control locked", d, 32'h1);
        rd(A_SEQ, d);  chk(d == 32'h0F05_0E02, "R11 store locked", d, 32'h0F050E02);
        rd(A_STAT, d); chk(d == 32'h23, "R11 status read-only", d, 32'h23);
        @(negedge clk); wake_irq = 1'b1;
        @(negedge clk); wake_irq = 1'b0;
        @(negedge clk); chk(pwr_o == 3'b101, "R6 resume", {29'd0, pwr_o}, 3'b101);
        @(negedge clk); chk(core_release, "R9 release after wait", {31'd0, core_release}, 1);

        // R7 early wake latched
        fire_wfi();
        wake_irq = 1'b1;
        @(negedge clk); wake_irq = 1'b0;
        repeat (3) @(negedge clk);
        @(negedge clk); chk(core_release, "R7 early wake kept", {31'd0, core_release}, 1);

        // R10 run past end of store
        for (int i = 0; i < 32; i++) mem_m[i] = 8'h01;
        load_mem();
        wr(A_CTRL, (32'd28 << 4) | 32'd1);
        fire_wfi();
        repeat (5) @(negedge clk);
        chk(pwr_o == 0 && !core_release, "R10 overrun outputs", {28'd0, core_release, pwr_o}, 0);
        rd(A_STAT, d); chk(d == 32'h4, "R10 overrun status", d, 32'h4);
        wr(A_SEQ, 32'h0F0F_0F01);
        wr(A_CTRL, 32'h1);
        fire_wfi();
        repeat (3) @(negedge clk);
        rd(A_STAT, d); chk(d == 32'h10, "R10 error cleared by launch", d, 32'h10);
        wr(A_CTRL, (32'd100 << 4) | 32'd1);
        fire_wfi();
        repeat (2) @(negedge clk);
        rd(A_STAT, d); chk(d == 32'h4, "R10 start index out of range", d, 32'h4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule